// File: doc/BRIEF.md
# Three-Wire Stepping Wiper Controller

This block drives the wiper of a 32-position digital potentiometer from three slow control pins that are not tied to any clock: an active-low select, a direction pin and a step strobe. Each pin is brought into the system clock domain and must hold a new level for a set number of cycles before the controller acts on it. While the block is selected, each falling edge of the filtered strobe moves a 5-bit position one tap. The direction level at that edge sets the way the wiper moves. The position is decoded into a one-hot select with one line per tap.

A retained register stands in for non-volatile storage. It is written when the select is released while the strobe is high. A system reset reloads the wiper from it, so the last saved position comes back after a reset. A separate power-on reset sets both the store and the wiper to a fixed start value. Each write holds a busy flag for a programmable number of cycles, and steps and further writes are ignored until the flag clears.

Top module: `stepper_pot_ctrl`

## Requirements
- R1: `tap_sel` has exactly one bit set, and it is bit number `wiper_pos`.
- R2: While selected (`cs_n_pin` low), each high-to-low change of `inc_pin` moves `wiper_pos` by exactly one. It moves up if `ud_pin` is 1 at that change and down if `ud_pin` is 0. At no other time does the position change, apart from the reset loads.
- R3: While `cs_n_pin` is high, activity on `inc_pin` and `ud_pin` leaves `wiper_pos` unchanged.
- R4: The position saturates. A step up at 31 stays at 31, a step down at 0 stays at 0, and neither wraps.
- R5: A low-to-high change of `cs_n_pin` while `inc_pin` is high saves `wiper_pos` to the retained store. A later `rst_n` pulse reloads `wiper_pos` from that store.
- R6: A low-to-high change of `cs_n_pin` while `inc_pin` is low saves nothing. The wiper keeps its value, and the next `rst_n` pulse restores the previously saved position.
- R7: A `por_n` pulse sets both the store and `wiper_pos` to NV_INIT (16 by default).
- R8: A save raises `store_busy` for STORE_BUSY_CYCLES cycles. While it is high, strobe edges do not move the wiper, and a new save neither changes the store nor extends the busy time.
- R9: A pin level that lasts fewer than DEBOUNCE_CYCLES clock cycles (4 by default) causes no step and no save.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; sets the retained store to NV_INIT |
| rst_n | input | 1 | System reset, active low; reloads the wiper from the store |
| cs_n_pin | input | 1 | Active-low select, not synchronous to clk |
| ud_pin | input | 1 | Direction: 1 steps up, 0 steps down; not synchronous to clk |
| inc_pin | input | 1 | Step strobe, acts on its falling edge; not synchronous to clk |
| wiper_pos | output | 5 | Current wiper position, 0 to 31 |
| tap_sel | output | 32 | One-hot tap select; bit n is set when the wiper is at tap n |
| store_busy | output | 1 | High while a save is in progress |

## Verification
The hardest case to reach from the pins is a second save that is refused because the busy window is still open. The stored value cannot change in that window, so a refused save and an accepted one would store the same value. The bench therefore starts a save, moves the pins through a full deselect, strobe and reselect sequence inside the window, and releases the select again with the strobe high. It then checks that `store_busy` drops at the time set by the first save and not later. Random sessions mix steps, closes with and without a save, resets and short strobe glitches. Each position and each restored value is checked against a saturating model kept in the bench.

// File: rtl/potstep_pkg.sv
package potstep_pkg;

   // Index of each control pin in the synchronizer array
   localparam int CH_SEL  = 0;
   localparam int CH_DIR  = 1;
   localparam int CH_STEP = 2;
   localparam int NUM_CH  = 3;

   // Idle level each filtered pin takes during reset: select off, strobe high
   localparam logic [NUM_CH-1:0] CH_IDLE = 3'b101;

endpackage

// File: rtl/pot_pin_filter.sv
module pot_pin_filter #(
   parameter int          STABLE_CYCLES = 4,
   parameter logic        IDLE_LEVEL    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic level
);

   localparam int CW = $clog2(STABLE_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

   logic          meta_q;
   logic          sync_q;
   logic [CW-1:0] run_q;

   // Two-flop synchronizer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= IDLE_LEVEL;
         sync_q <= IDLE_LEVEL;
      end else begin
         meta_q <= pin_async;
         sync_q <= meta_q;
      end
   end

   // Level changes only after STABLE_CYCLES consecutive differing samples
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= IDLE_LEVEL;
         run_q <= '0;
      end else if (sync_q == level) begin
         run_q <= '0;
      end else if (run_q == LAST) begin
         level <= sync_q;
         run_q <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   // R9
   filter_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level != $past(level)) |-> ($past(sync_q) == level));

endmodule

// File: rtl/pot_wiper_counter.sv
module pot_wiper_counter #(
   parameter int POS_BITS = 5
) (
   input  logic                clk,
   input  logic                load,
   input  logic [POS_BITS-1:0] load_val,
   input  logic                step_en,
   input  logic                step_up,
   output logic [POS_BITS-1:0] pos
);

   localparam logic [POS_BITS-1:0] TOP = {POS_BITS{1'b1}};
   localparam logic [POS_BITS-1:0] BOT = '0;

   logic at_top;
   logic at_bot;

   assign at_top = (pos == TOP);
   assign at_bot = (pos == BOT);

   always_ff @(posedge clk) begin
      if (load) begin
         pos <= load_val;
      end else if (step_en) begin
         if (step_up && !at_top) begin
            pos <= pos + 1'b1;
         end else if (!step_up && !at_bot) begin
            pos <= pos - 1'b1;
         end
      end
   end

   // R2
   single_step_chk: assert property (@(posedge clk) disable iff (load)
      1'b1 |=> ((pos == $past(pos)) ||
                (pos == POS_BITS'($past(pos) + 1'b1)) ||
                (pos == POS_BITS'($past(pos) - 1'b1))));

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (load)
      !step_en |=> $stable(pos));

   // R4
   top_sat_chk: assert property (@(posedge clk) disable iff (load)
      (at_top && step_en && step_up) |=> (pos == TOP));

   // R4
   bot_sat_chk: assert property (@(posedge clk) disable iff (load)
      (at_bot && step_en && !step_up) |=> (pos == BOT));

endmodule

// File: rtl/pot_nv_cell.sv
module pot_nv_cell #(
   parameter int POS_BITS    = 5,
   parameter int BUSY_CYCLES = 64,
   parameter int NV_INIT     = 16
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                store_req,
   input  logic [POS_BITS-1:0] store_val,
   output logic [POS_BITS-1:0] nv_q,
   output logic                busy
);

   logic accept;

   generate
      if (BUSY_CYCLES == 0) begin : g_no_busy
         assign busy   = 1'b0;
         assign accept = store_req;
      end else begin : g_busy
         localparam int BW = $clog2(BUSY_CYCLES + 1);
         logic [BW-1:0] left_q;

         assign busy   = (left_q != '0);
         assign accept = store_req && !busy;

         always_ff @(posedge clk) begin
            if (!por_n) begin
               left_q <= '0;
            end else if (accept) begin
               left_q <= BW'(BUSY_CYCLES);
            end else if (busy) begin
               left_q <= left_q - 1'b1;
            end
         end
      end
   endgenerate

   // Retained value: cleared only by power-on reset
   always_ff @(posedge clk) begin
      if (!por_n) begin
         nv_q <= POS_BITS'(NV_INIT);
      end else if (accept) begin
         nv_q <= store_val;
      end
   end

   // R5
   nv_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
      !store_req |=> $stable(nv_q));

   // R8
   busy_block_chk: assert property (@(posedge clk) disable iff (!por_n)
      (store_req && busy) |=> $stable(nv_q));

endmodule

// File: rtl/pot_tap_decoder.sv
module pot_tap_decoder #(
   parameter int POS_BITS = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [POS_BITS-1:0]       pos,
   output logic [(1<<POS_BITS)-1:0]  tap
);

   localparam int TAPS = 1 << POS_BITS;

   generate
      for (genvar t = 0; t < TAPS; t++) begin : g_tap
         assign tap[t] = (pos == POS_BITS'(t));
      end
   endgenerate

   // R1
   tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap) == 1);

   // R1
   tap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap[pos] == 1'b1);

endmodule

// File: rtl/stepper_pot_ctrl.sv
module stepper_pot_ctrl #(
   parameter int POS_BITS          = 5,
   parameter int DEBOUNCE_CYCLES   = 4,
   parameter int STORE_BUSY_CYCLES = 64,
   parameter int NV_INIT           = 16
) (
   input  logic                     clk,
   input  logic                     por_n,
   input  logic                     rst_n,
   input  logic                     cs_n_pin,
   input  logic                     ud_pin,
   input  logic                     inc_pin,
   output logic [POS_BITS-1:0]      wiper_pos,
   output logic [(1<<POS_BITS)-1:0] tap_sel,
   output logic                     store_busy
);

   import potstep_pkg::*;

   localparam int TAPS = 1 << POS_BITS;

   // Elaboration-time parameter checks
   generate
      if (POS_BITS < 1 || POS_BITS > 8) begin : g_bad_bits
         $error("POS_BITS must be between 1 and 8");
      end
      if (DEBOUNCE_CYCLES < 1) begin : g_bad_deb
         $error("DEBOUNCE_CYCLES must be at least 1");
      end
      if (STORE_BUSY_CYCLES < 0) begin : g_bad_busy
         $error("STORE_BUSY_CYCLES must not be negative");
      end
      if (NV_INIT < 0 || NV_INIT >= TAPS) begin : g_bad_init
         $error("NV_INIT must address an existing tap");
      end
   endgenerate

   logic              sys_rst_n;
   logic [NUM_CH-1:0] pin_vec;
   logic [NUM_CH-1:0] filt;
   logic              sel_off;
   logic              dir_up;
   logic              strobe;
   logic              sel_off_d;
   logic              strobe_d;
   logic              step_en;
   logic              store_req;
   logic              load;
   logic [POS_BITS-1:0] load_val;
   logic [POS_BITS-1:0] nv_val;

   assign sys_rst_n = rst_n & por_n;

   assign pin_vec[CH_SEL]  = cs_n_pin;
   assign pin_vec[CH_DIR]  = ud_pin;
   assign pin_vec[CH_STEP] = inc_pin;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
         pot_pin_filter #(
            .STABLE_CYCLES (DEBOUNCE_CYCLES),
            .IDLE_LEVEL    (CH_IDLE[c])
         ) u_filt (
            .clk       (clk),
            .rst_n     (sys_rst_n),
            .pin_async (pin_vec[c]),
            .level     (filt[c])
         );
      end
   endgenerate

   assign sel_off = filt[CH_SEL];
   assign dir_up  = filt[CH_DIR];
   assign strobe  = filt[CH_STEP];

   // Previous filtered levels for edge detection
   always_ff @(posedge clk) begin
      if (!sys_rst_n) begin
         sel_off_d <= CH_IDLE[CH_SEL];
         strobe_d  <= CH_IDLE[CH_STEP];
      end else begin
         sel_off_d <= sel_off;
         strobe_d  <= strobe;
      end
   end

   assign step_en   = strobe_d && !strobe && !sel_off && !store_busy;
   assign store_req = !sel_off_d && sel_off && strobe;

   assign load     = !sys_rst_n;
   assign load_val = por_n ? nv_val : POS_BITS'(NV_INIT);

   pot_wiper_counter #(
      .POS_BITS (POS_BITS)
   ) u_ctr (
      .clk      (clk),
      .load     (load),
      .load_val (load_val),
      .step_en  (step_en),
      .step_up  (dir_up),
      .pos      (wiper_pos)
   );

   pot_nv_cell #(
      .POS_BITS    (POS_BITS),
      .BUSY_CYCLES (STORE_BUSY_CYCLES),
      .NV_INIT     (NV_INIT)
   ) u_nv (
      .clk       (clk),
      .por_n     (por_n),
      .store_req (store_req),
      .store_val (wiper_pos),
      .nv_q      (nv_val),
      .busy      (store_busy)
   );

   pot_tap_decoder #(
      .POS_BITS (POS_BITS)
   ) u_dec (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .pos   (wiper_pos),
      .tap   (tap_sel)
   );

   // R3
   deselect_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      sel_off |=> $stable(wiper_pos));

   // R8
   busy_freeze_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
      store_busy |=> $stable(wiper_pos));

endmodule

// File: tb/stepper_pot_ctrl_tb.sv
module stepper_pot_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DEB        = 4;
   localparam int BUSY       = 200;
   localparam int INIT       = 16;
   localparam int HOLD       = 12;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n_pin = 1'b1;
   logic        ud_pin = 1'b0;
   logic        inc_pin = 1'b1;
   logic [4:0]  wiper_pos;
   logic [31:0] tap_sel;
   logic        store_busy;

   int checks = 0;
   int fails  = 0;
   int exp_pos;
   int exp_nv;

   always #(CLK_PERIOD/2) clk = ~clk;

   stepper_pot_ctrl #(
      .POS_BITS          (5),
      .DEBOUNCE_CYCLES   (DEB),
      .STORE_BUSY_CYCLES (BUSY),
      .NV_INIT           (INIT)
   ) u_dut (
      .clk        (clk),
      .por_n      (por_n),
      .rst_n      (rst_n),
      .cs_n_pin   (cs_n_pin),
      .ud_pin     (ud_pin),
      .inc_pin    (inc_pin),
      .wiper_pos  (wiper_pos),
      .tap_sel    (tap_sel),
      .store_busy (store_busy)
   );

   function automatic int sat_step(input int p, input bit up);
      if (up) return (p == 31) ? 31 : p + 1;
      return (p == 0) ? 0 : p - 1;
   endfunction

   task automatic check_val(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_pos(input string tag, input int e);
      logic [31:0] exp_tap;
      exp_tap = 32'd1 << e;
      check_val({tag, " wiper"}, int'(wiper_pos), e);
      checks++;
      if (tap_sel !== exp_tap) begin
         fails++;
         $display("FAIL R1 %s tap: actual %h expected %h", tag, tap_sel, exp_tap);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pins(input logic cs, input logic ud, input logic inc);
      @(negedge clk);
      cs_n_pin = cs;
      ud_pin   = ud;
      inc_pin  = inc;
      wait_clk(HOLD);
   endtask

   // Select with strobe high
   task automatic select();
      set_pins(1'b0, ud_pin, 1'b1);
   endtask

   // Full strobe pulse with a given direction
   task automatic pulse(input logic up);
      set_pins(cs_n_pin, up, inc_pin);
      set_pins(cs_n_pin, up, 1'b0);
      set_pins(cs_n_pin, up, 1'b1);
   endtask

   task automatic sys_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(HOLD);
      exp_pos = exp_nv;
   endtask

   task automatic power_on();
      @(negedge clk);
      por_n = 1'b0;
      rst_n = 1'b0;
      wait_clk(4);
      por_n = 1'b1;
      rst_n = 1'b1;
      wait_clk(HOLD);
      exp_nv  = INIT;
      exp_pos = INIT;
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int seed_init;
      int op;
      logic up;
      seed_init = $urandom(32'd7715);

      // Reset state
      power_on();
      check_pos("R7 power-on", INIT);
      check_val("R8 idle busy", int'(store_busy), 0);

      // Direction both ways
      select();
      for (int i = 0; i < 3; i++) begin
         pulse(1'b1);
         exp_pos = sat_step(exp_pos, 1'b1);
      end
      check_pos("R2 up x3", exp_pos);
      for (int i = 0; i < 2; i++) begin
         pulse(1'b0);
         exp_pos = sat_step(exp_pos, 1'b0);
      end
      check_pos("R2 down x2", exp_pos);

      // Saturation at both ends
      for (int i = 0; i < 16; i++) pulse(1'b1);
      exp_pos = 31;
      check_pos("R4 top", exp_pos);
      for (int i = 0; i < 33; i++) pulse(1'b0);
      exp_pos = 0;
      check_pos("R4 bottom", exp_pos);

      // Short strobe glitch
      @(negedge clk);
      inc_pin = 1'b0;
      wait_clk(2);
      inc_pin = 1'b1;
      wait_clk(HOLD);
      check_pos("R9 glitch", exp_pos);

      for (int i = 0; i < 5; i++) pulse(1'b1);
      exp_pos = 5;

      // Save, then exercise the busy window
      set_pins(1'b1, ud_pin, 1'b1);
      exp_nv = exp_pos;
      check_val("R8 busy raised", int'(store_busy), 1);
      set_pins(1'b0, 1'b1, 1'b1);
      set_pins(1'b0, 1'b1, 1'b0);
      set_pins(1'b0, 1'b1, 1'b1);
      check_pos("R8 step blocked", exp_pos);
      set_pins(1'b1, 1'b1, 1'b1);
      wait_clk(225 - 5 * HOLD);
      check_val("R8 busy not extended", int'(store_busy), 0);
      sys_reset();
      check_pos("R5 restore", exp_pos);

      // Close without saving
      select();
      for (int i = 0; i < 3; i++) begin
         pulse(1'b1);
         exp_pos = sat_step(exp_pos, 1'b1);
      end
      set_pins(1'b0, 1'b1, 1'b0);
      exp_pos = sat_step(exp_pos, 1'b1);
      set_pins(1'b1, 1'b1, 1'b0);
      set_pins(1'b1, 1'b1, 1'b1);
      check_pos("R6 kept", exp_pos);
      pulse(1'b0);
      pulse(1'b1);
      check_pos("R3 deselected", exp_pos);
      sys_reset();
      check_pos("R6 restore old", exp_pos);

      // Power-on clears the store
      power_on();
      sys_reset();
      check_pos("R7 store init", INIT);

      // Random sessions
      for (int n = 0; n < 60; n++) begin
         op = int'($urandom_range(0, 6));
         up = 1'($urandom_range(0, 1));
         case (op)
            0, 1, 2: begin
               if (cs_n_pin) select();
               pulse(up);
               exp_pos = sat_step(exp_pos, up);
               check_pos("R2 random step", exp_pos);
            end
            3: begin
               if (cs_n_pin) select();
               set_pins(1'b0, up, 1'b0);
               exp_pos = sat_step(exp_pos, up);
               set_pins(1'b1, up, 1'b0);
               set_pins(1'b1, up, 1'b1);
               pulse(~up);
               check_pos("R3 random deselected", exp_pos);
            end
            4: begin
               if (cs_n_pin) select();
               set_pins(1'b1, up, 1'b1);
               exp_nv = exp_pos;
               wait_clk(BUSY + 20);
               check_val("R8 random busy done", int'(store_busy), 0);
            end
            5: begin
               sys_reset();
               check_pos("R5 random restore", exp_pos);
            end
            default: begin
               if (cs_n_pin) select();
               @(negedge clk);
               inc_pin = 1'b0;
               wait_clk(DEB - 2);
               inc_pin = 1'b1;
               wait_clk(HOLD);
               check_pos("R9 random glitch", exp_pos);
            end
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule